// File: doc/BRIEF.md
# Serial Programming Command Interface

This block is the device-side end of a serial programming link. An external programmer drives a frame strobe (`prog_load`), a serial clock (`prog_clk`) and a data line (`prog_sdi`). The block answers on a single output (`prog_sdo`). While the strobe is high, a 32-bit command enters most significant bit first, one bit per rising edge of the serial clock. At the same time, the 32-bit response to the previous command leaves on `prog_sdo`. When the strobe falls after exactly 32 bits, two further serial clock pulses execute the command against an on-block byte store. The command can be a byte read, a byte write, a byte erase, a page write or a page erase. The second execute edge completes the access.

All three link inputs are oversampled by the block clock through a synchronizer. The byte store stands in for the non-volatile memory and has two spaces (code and data) of 1024 bytes each. A page write or a page erase holds `prog_sdo` low for `BUSY_CYCLES` block clock cycles as a busy indication. Because responses trail commands by one frame, the programmer shifts one extra dummy command to collect the final result.

Top module: `prog_link_slave`

## Requirements
- R1: While `prog_load` is high, each `prog_clk` rising edge shifts one `prog_sdi` bit into the command, bit 31 first. After the k-th edge of a frame (k = 1..32), `prog_sdo` carries bit 32-k of the response to the previous executed command.
- R2: Response bits 31..8 equal bits 31..8 of the previous executed command. Bits 7..0 equal that command's bits 7..0 unless it was a valid read.
- R3: A valid command with bit 24 = 1 is a read. Response bits 7..0 are the byte stored at the addressed location, sampled at the second execute edge. The location is space bit 29 (1 = data, 0 = code) combined with address bits 17..8.
- R4: A valid byte write (bit 31 = 0, bit 24 = 0, bit 22 = 0) stores bits 7..0 at the addressed location in the selected space. The other space and other addresses are left unchanged.
- R5: A valid byte write with erase bit 22 = 1 stores 8'hFF at the addressed location instead of bits 7..0.
- R6: A valid page write (bit 31 = 1, bit 24 = 0) stores its byte like a byte write. After the second execute edge, `prog_sdo` is low for exactly `BUSY_CYCLES` block clock cycles and is high otherwise.
- R7: A valid page write with bit 22 = 1 sets every byte of the `PAGE_BYTES`-aligned page that contains the address to 8'hFF, and leaves bytes outside the page unchanged. The busy time is the same as in R6.
- R8: A command is valid only if bits 30, 27..25, 23 and 21..18 are zero and exactly one of bits 29 and 28 is set. An invalid command makes no memory access and raises no busy. Its response echoes all 32 received bits.
- R9: If `prog_load` falls after a count other than 32 bits, the frame is discarded. Its execute pulses do nothing. The next frame returns the same response as the discarded one did.
- R10: After reset, and whenever `prog_load` is low and no busy period is running, `prog_sdo` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also times the busy period |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_load | input | 1 | Frame strobe: high to shift, low to execute |
| prog_clk | input | 1 | Serial clock from the programmer |
| prog_sdi | input | 1 | Serial command bit |
| prog_sdo | output | 1 | Serial response bit, low while a page operation is busy |

## Verification
Each serial clock edge reaches the shift logic three block cycles after it changes at the pins: two synchronizer stages, then the edge detector. For that reason the bench holds every serial level for six block cycles and reads `prog_sdo` at the end of each high phase. A result shows up one whole frame later, so every response check is made against the model value of the preceding executed command, and the first frame after reset is not checked. The busy window opens three or four cycles after the second execute edge. It is measured by counting low samples of `prog_sdo` on every block cycle over a window of `BUSY_CYCLES` plus 40 cycles, which must give exactly `BUSY_CYCLES` for page operations and zero for all others.

// File: rtl/prog_link_pkg.sv
// Package: field positions, validity mask and decode for the 32-bit
// programming command word shared by the serial link modules.
package prog_link_pkg;

    localparam int CMD_W    = 32;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int MEM_AW   = ADDR_W + 1;  // space bit on top of address

    localparam int B_PAGE   = 31;
    localparam int B_DSPACE = 29;
    localparam int B_CSPACE = 28;
    localparam int B_READ   = 24;
    localparam int B_ERASE  = 22;
    localparam int ADDR_LSB = 8;

    // Bits that must be zero for a command to be acted on.
    localparam logic [CMD_W-1:0] RSV_MASK = 32'h4EBC_0000;

    typedef struct packed {
        logic              valid;
        logic              page;
        logic              data_space;
        logic              read;
        logic              erase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    // Split a received word into its fields and judge its validity.
    function automatic cmd_t decode_cmd(logic [CMD_W-1:0] w);
        cmd_t c;
        c.valid      = ((w & RSV_MASK) == '0) && (w[B_DSPACE] ^ w[B_CSPACE]);
        c.page       = w[B_PAGE];
        c.data_space = w[B_DSPACE];
        c.read       = w[B_READ];
        c.erase      = w[B_ERASE];
        c.addr       = w[ADDR_LSB +: ADDR_W];
        c.wdata      = w[DATA_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/prog_link_sync.sv
// Module: prog_link_sync
// Brings the three asynchronous link pins into the block clock domain
// and derives single-cycle edge strobes. Assumes each pin level is held
// for well over STAGES+1 block cycles, with data stable before its
// serial clock edge.
module prog_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic load_s,
    output logic load_rise,
    output logic load_fall,
    output logic sclk_rise,
    output logic sdi_s
);
    logic [STAGES-1:0] load_ff, sclk_ff, sdi_ff;
    logic              load_d, sclk_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_ff <= '0;
            sclk_ff <= '0;
            sdi_ff  <= '0;
            load_d  <= 1'b0;
            sclk_d  <= 1'b0;
        end else begin
            load_ff <= {load_ff[STAGES-2:0], load_i};
            sclk_ff <= {sclk_ff[STAGES-2:0], sclk_i};
            sdi_ff  <= {sdi_ff[STAGES-2:0], sdi_i};
            load_d  <= load_ff[STAGES-1];
            sclk_d  <= sclk_ff[STAGES-1];
        end
    end

    assign load_s    = load_ff[STAGES-1];
    assign sdi_s     = sdi_ff[STAGES-1];
    assign load_rise = load_s & ~load_d;
    assign load_fall = ~load_s & load_d;
    assign sclk_rise = sclk_ff[STAGES-1] & ~sclk_d;

endmodule

// File: rtl/prog_link_shifter.sv
// Module: prog_link_shifter
// Frame engine: shifts the command in and the pending response out while
// the strobe is high. It arms execution only when exactly CMD_W bits have
// arrived and then turns the two following serial edges into issue and
// fire strobes. Assumes no serial edge coincides with a strobe edge.
module prog_link_shifter
    import prog_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_s,
    input  logic             load_rise,
    input  logic             load_fall,
    input  logic             sclk_rise,
    input  logic             sdi_s,
    input  logic [CMD_W-1:0] rsp_word,
    output logic [CMD_W-1:0] cmd_word,
    output logic             exec_issue,
    output logic             exec_fire,
    output logic             so_bit
);
    localparam int          CNT_W = $clog2(CMD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(CMD_W + 1);

    logic [CMD_W-1:0] cmd_sr, rsp_sr;
    logic [CNT_W-1:0] bit_cnt;
    logic             armed, pulse_seen;
    logic             shift_step, exec_step;

    assign shift_step = sclk_rise & load_s;
    assign exec_step  = sclk_rise & ~load_s & armed;
    assign exec_issue = exec_step & ~pulse_seen;
    assign exec_fire  = exec_step & pulse_seen;

    // Frame sequencing: load response, shift bits, arm and count execute edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sr     <= '0;
            rsp_sr     <= '0;
            cmd_word   <= '0;
            bit_cnt    <= '0;
            armed      <= 1'b0;
            pulse_seen <= 1'b0;
            so_bit     <= 1'b1;
        end else if (load_rise) begin
            bit_cnt <= '0;
            rsp_sr  <= rsp_word;
            armed   <= 1'b0;
            so_bit  <= 1'b1;
        end else if (shift_step) begin
            cmd_sr <= {cmd_sr[CMD_W-2:0], sdi_s};
            rsp_sr <= {rsp_sr[CMD_W-2:0], 1'b0};
            so_bit <= rsp_sr[CMD_W-1];
            if (bit_cnt != SAT) bit_cnt <= bit_cnt + 1'b1;
        end else if (load_fall) begin
            armed      <= (bit_cnt == FULL);
            pulse_seen <= 1'b0;
            so_bit     <= 1'b1;
            if (bit_cnt == FULL) cmd_word <= cmd_sr;
        end else if (exec_step) begin
            pulse_seen <= 1'b1;
            if (pulse_seen) armed <= 1'b0;
        end
    end

    // R1: the bit counter never runs past its saturation value.
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= SAT);

    // R9: execution is armed only after a frame of exactly CMD_W bits.
    a_r9_arm_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(bit_cnt) == FULL);

    // R9: issue and fire never occur in the same cycle.
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_issue && exec_fire));

endmodule

// File: rtl/prog_link_exec.sv
// Module: prog_link_exec
// Runs a decoded command. A read is issued on the first execute edge and
// captured on the second. A write or byte erase lands on the second edge,
// and a page erase sweeps the page one byte per cycle. Page operations
// start the busy counter. Assumes the programmer waits out the busy
// period and that PAGE_BYTES is a power of two no larger than BUSY_CYCLES.
module prog_link_exec
    import prog_link_pkg::*;
#(
    parameter int BUSY_CYCLES = 64,
    parameter int PAGE_BYTES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              exec_issue,
    input  logic              exec_fire,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mem_re,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CMD_W-1:0]  rsp_word,
    output logic              busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam int SW = $clog2(PAGE_BYTES + 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);

    cmd_t              c;
    logic [BW-1:0]     busy_cnt;
    logic [SW-1:0]     sweep_left;
    logic [MEM_AW-1:0] sweep_addr;
    logic              sweeping, do_write, page_erase;

    assign c          = decode_cmd(cmd_word);
    assign sweeping   = (sweep_left != '0);
    assign do_write   = exec_fire & c.valid & ~c.read;
    assign page_erase = do_write & c.page & c.erase;
    assign busy       = (busy_cnt != '0);

    // Memory port: sweep has priority, otherwise the command's own location.
    always_comb begin
        mem_re    = exec_issue & c.valid & c.read;
        mem_we    = (do_write & ~page_erase) | sweeping;
        mem_addr  = sweeping ? sweep_addr : {c.data_space, c.addr};
        mem_wdata = (sweeping | c.erase) ? {DATA_W{1'b1}} : c.wdata;
    end

    // Response capture, busy countdown and page-erase sweep state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_word   <= '0;
            busy_cnt   <= '0;
            sweep_left <= '0;
            sweep_addr <= '0;
        end else begin
            if (exec_fire)
                rsp_word <= {cmd_word[CMD_W-1:DATA_W],
                             (c.valid && c.read) ? rd_data : cmd_word[DATA_W-1:0]};
            if (do_write && c.page)
                busy_cnt <= BW'(BUSY_CYCLES);
            else if (busy)
                busy_cnt <= busy_cnt - 1'b1;
            if (page_erase) begin
                sweep_left <= SW'(PAGE_BYTES);
                sweep_addr <= {c.data_space, c.addr & PAGE_MASK};
            end else if (sweeping) begin
                sweep_left <= sweep_left - 1'b1;
                sweep_addr <= sweep_addr + 1'b1;
            end
        end
    end

    // R6: a busy period begins at its full length.
    a_r6_busy_starts_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> busy_cnt == BW'(BUSY_CYCLES));

    // R6: busy ends one cycle after the counter reaches one.
    a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt == BW'(1) && !exec_fire) |=> !busy);

    // R7: the erase sweep always runs inside a busy period.
    a_r7_sweep_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> busy);

    // R8: an invalid command writes nothing and starts no busy period.
    a_r8_invalid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_fire && !c.valid && !sweeping) |-> !mem_we ##1 !$rose(busy));

endmodule

// File: rtl/prog_link_store.sv
// Module: prog_link_store
// Stand-in for the non-volatile array: a byte RAM with one synchronous
// read or write per cycle. Read data is registered and holds until the
// next read. The array has no reset.
module prog_link_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/prog_link_slave.sv
// Module: prog_link_slave
// Top of the serial programming slave. It joins the synchronizer, the
// frame engine, the command executor and the byte store. The response
// line is pulled low during busy periods and idles high when no frame
// is being shifted.
module prog_link_slave
    import prog_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYCLES = 64,
    parameter int PAGE_BYTES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_load,
    input  logic prog_clk,
    input  logic prog_sdi,
    output logic prog_sdo
);
    logic              load_s, load_rise, load_fall, sclk_rise, sdi_s;
    logic [CMD_W-1:0]  cmd_word, rsp_word;
    logic              exec_issue, exec_fire, so_bit, busy;
    logic              mem_re, mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, rd_data;

    prog_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .load_i(prog_load), .sclk_i(prog_clk), .sdi_i(prog_sdi),
        .load_s(load_s), .load_rise(load_rise), .load_fall(load_fall),
        .sclk_rise(sclk_rise), .sdi_s(sdi_s)
    );

    prog_link_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .load_s(load_s), .load_rise(load_rise), .load_fall(load_fall),
        .sclk_rise(sclk_rise), .sdi_s(sdi_s), .rsp_word(rsp_word),
        .cmd_word(cmd_word), .exec_issue(exec_issue), .exec_fire(exec_fire),
        .so_bit(so_bit)
    );

    prog_link_exec #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .cmd_word(cmd_word), .exec_issue(exec_issue), .exec_fire(exec_fire),
        .rd_data(rd_data), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rsp_word(rsp_word), .busy(busy)
    );

    prog_link_store #(.AW(MEM_AW), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .re(mem_re), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(rd_data)
    );

    // Output select: busy low, shifted bit while framing, otherwise high.
    always_comb begin
        if (busy)        prog_sdo = 1'b0;
        else if (load_s) prog_sdo = so_bit;
        else             prog_sdo = 1'b1;
    end

    // R10: with the strobe low and no busy period, the line stays high.
    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_s && !busy) |-> prog_sdo);

    // R6: the line is never high during a busy period.
    a_r6_low_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_sdo);

endmodule

// File: tb/prog_link_slave_bench.sv
// Bench: sweeps writes, reads, erases, page operations, invalid words and
// aborted frames through the serial pins. Expected values come from a
// byte-array model of the requirements.
module prog_link_slave_bench;
    localparam int BUSY = 20;
    localparam int PAGE = 4;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_load = 1'b0, prog_clk = 1'b0, prog_sdi = 1'b0;
    logic prog_sdo;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0]  mdl [0:2047];
    logic [31:0] exp_prev;
    string       prev_tag;
    bit          have_prev = 0;

    always #10 clk = ~clk;

    prog_link_slave #(.SYNC_STAGES(2), .BUSY_CYCLES(BUSY), .PAGE_BYTES(PAGE)) u_prog_link_slave (
        .clk(clk), .rst_n(rst_n), .prog_load(prog_load), .prog_clk(prog_clk),
        .prog_sdi(prog_sdi), .prog_sdo(prog_sdo)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit page, bit dsp, bit csp, bit rd, bit er,
                                       int addr, int data);
        logic [31:0] w = '0;
        w[31] = page; w[29] = dsp; w[28] = csp; w[24] = rd; w[22] = er;
        w[17:8] = addr[9:0]; w[7:0] = data[7:0];
        return w;
    endfunction

    // Shift nbits of a frame, then drop the strobe and apply two pulses,
    // counting low samples of the response line after the second pulse.
    task automatic run_frame(logic [31:0] cmd, int nbits,
                             output logic [31:0] rsp, output int lows);
        rsp = '0;
        prog_load = 1'b1;
        tick(8);
        for (int i = 0; i < nbits; i++) begin
            prog_sdi = cmd[31-i];
            tick(H);
            prog_clk = 1'b1;
            tick(H);
            rsp[31-i] = prog_sdo;
            prog_clk = 1'b0;
        end
        tick(H);
        prog_load = 1'b0;
        tick(8);
        prog_clk = 1'b1; tick(H); prog_clk = 1'b0; tick(H);
        prog_clk = 1'b1;
        lows = 0;
        for (int k = 0; k < BUSY + 40; k++) begin
            tick(1);
            if (!prog_sdo) lows++;
            if (k == H) prog_clk = 1'b0;
        end
        tick(4);
    endtask

    // Issue a full command, check the previous response, update the model.
    task automatic issue(logic [31:0] cmd, string tag);
        logic [31:0] rsp, exp;
        int lows, exp_lows;
        bit valid;
        logic [10:0] idx;
        run_frame(cmd, 32, rsp, lows);
        if (have_prev) check(rsp == exp_prev, prev_tag, rsp, exp_prev);
        valid = ((cmd & 32'h4EBC_0000) == 0) && (cmd[29] ^ cmd[28]);
        idx = {cmd[29], cmd[17:8]};
        exp = cmd;
        exp_lows = 0;
        if (valid && cmd[24]) begin
            exp[7:0] = mdl[idx];
        end else if (valid) begin
            if (cmd[31]) exp_lows = BUSY;
            if (cmd[31] && cmd[22]) begin
                for (int p = 0; p < PAGE; p++)
                    mdl[{idx[10:2], 2'b00} + 11'(p)] = 8'hFF;
            end else begin
                mdl[idx] = cmd[22] ? 8'hFF : cmd[7:0];
            end
        end
        check(lows == exp_lows, (exp_lows != 0) ? tag : "R10 busy-free", lows, exp_lows);
        exp_prev  = exp;
        prev_tag  = tag;
        have_prev = 1;
    endtask

    function automatic int addr_of(int j);
        return (j < 4) ? j : (j < 6) ? 507 + j : 1016 + j;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R10: line high after reset.
        check(prog_sdo == 1'b1, "R10 reset", {31'b0, prog_sdo}, 32'd1);

        // R4 byte writes to both spaces over boundary addresses (response check R1 R2).
        for (int s = 0; s < 2; s++)
            for (int j = 0; j < 8; j++)
                issue(mk(0, s == 1, s == 0, 0, 0, addr_of(j),
                         (addr_of(j) * 37 + s * 101 + 13) & 255), "R1 R2 R4");
        // R3 reads back every location.
        for (int s = 0; s < 2; s++)
            for (int j = 0; j < 8; j++)
                issue(mk(0, s == 1, s == 0, 1, 0, addr_of(j), 0), "R3");

        // R5 byte erase, then read.
        issue(mk(0, 0, 1, 0, 1, 2, 8'h12), "R5");
        issue(mk(0, 0, 1, 1, 0, 2, 0), "R5");

        // R6 page write with busy, then read.
        issue(mk(1, 0, 1, 0, 0, 700, 8'h3C), "R6");
        issue(mk(0, 0, 1, 1, 0, 700, 0), "R6");

        // R7 page erase: prefill data 7..12, erase page of 10, read all.
        for (int a = 7; a < 13; a++) issue(mk(0, 1, 0, 0, 0, a, a * 3 + 1), "R4");
        issue(mk(1, 1, 0, 0, 1, 10, 8'h55), "R7");
        for (int a = 7; a < 13; a++) issue(mk(0, 1, 0, 1, 0, a, 0), "R7");

        // R8 invalid words: reserved bits, both spaces, no space, invalid page.
        issue(mk(0, 0, 1, 0, 0, 0, 8'hEE) | 32'h4000_0000, "R8");
        issue(mk(0, 1, 1, 0, 0, 0, 8'hEE), "R8");
        issue(mk(0, 0, 0, 0, 0, 0, 8'hEE), "R8");
        issue(mk(1, 0, 1, 0, 0, 0, 8'hEE) | 32'h0010_0000, "R8");
        issue(mk(0, 0, 1, 1, 0, 0, 0) | 32'h0200_0000, "R8");
        issue(mk(0, 0, 1, 1, 0, 0, 0), "R8");
        issue(mk(0, 1, 0, 1, 0, 0, 0), "R8");

        // R9 aborted frame: 20 bits of a write, then a read of that location.
        begin
            logic [31:0] r;
            int l;
            run_frame(mk(0, 0, 1, 0, 0, 1, 8'h99), 20, r, l);
            check(l == 0, "R9 no busy", l, 0);
            prev_tag = "R9";
        end
        issue(mk(0, 0, 1, 1, 0, 1, 0), "R9");
        // Dummy command to collect the last result.
        issue(mk(0, 0, 1, 1, 0, 3, 0), "R3");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule